// File: doc/BRIEF.md
# Bulk OUT Endpoint Status Register

This block holds the control and status word for one bulk OUT endpoint of a full-speed USB device. Software sees a single 32-bit word through a simple register write strobe and a combinational read bus. The endpoint logic feeds it per-packet pulses (packet finished, packet was short, STALL went out) and the current receive FIFO occupancy in bytes and in whole packets. The FIFO storage and the serial protocol engine sit outside.

The word combines three kinds of fields. Live status fields mirror the FIFO state directly: one shows whether any data is present and one shows whether at least one whole packet is waiting. Sticky event fields latch packet completion and STALL transmission until software writes 1 to them. A short-packet flag marks that the most recent packet was short. A read/write control field makes the endpoint answer OUT tokens with STALL, and it is also driven out to the protocol engine.

The endpoint side must present the FIFO levels that already include a packet by the cycle its `pkt_done` pulse is asserted.

Top module: `bulk_out_ep_csr`

## Requirements
- R1: After reset every bit of `csr_rdata` reads 0 when both FIFO levels are 0, and `force_stall` is 0.
- R2: Bits 31:7 and bit 2 always read 0, whatever is written.
- R3: Bit 0 (packet ready) reads 1 in the same cycle that `fifo_pkts` is non-zero, and 0 otherwise.
- R4: Bit 5 (data present) reads 1 in the same cycle that `fifo_bytes` is non-zero, and 0 otherwise.
- R5: Bit 1 (packet complete) reads 1 from the cycle after a `pkt_done` pulse. A write with bit 1 set clears it in the next cycle, a write with bit 1 at 0 leaves it unchanged, and a `pkt_done` in the same cycle as a clearing write leaves it set.
- R6: Bit 3 (stall sent) reads 1 from the cycle after a `stall_sent` pulse. It is cleared, held or kept set by writes under the same rules as bit 1.
- R7: Bit 4 (force stall) takes the written value of bit 4 in the cycle after any write, holds it otherwise, and `force_stall` always equals it.
- R8: Bit 6 (short packet) reads 1 from the cycle after `pkt_done` with `pkt_short` high. It reads 0 from the cycle after `pkt_done` with `pkt_short` low. Without `pkt_done`, it reads 0 from the cycle after one in which `fifo_pkts` is 0.
- R9: Writes to bits 0, 5 and 6 have no effect on what those bits read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| pkt_done | input | 1 | One-cycle pulse: an OUT packet was received |
| pkt_short | input | 1 | Qualifies `pkt_done`: the packet was short |
| stall_sent | input | 1 | One-cycle pulse: a STALL handshake was sent |
| fifo_bytes | input | 7 | Bytes currently held in the receive FIFO |
| fifo_pkts | input | 2 | Whole packets currently held in the receive FIFO |
| force_stall | output | 1 | Requests STALL replies to OUT tokens |

## Verification
A wrong sticky state shows at the read port one cycle after the event or write that should have changed it. Examples are a complete flag lost to a same-cycle clear, or a stall-sent flag cleared by a zero write. A corrupted stall control appears on `force_stall` in that same cycle. The live FIFO fields have no state of their own, so any error in them shows with no delay. The short-packet flag can keep a stale value across a drained FIFO, and that shows one cycle after `fifo_pkts` reaches 0. Comparing the whole word and `force_stall` against a reference model on every clock catches each of these at the first cycle it occurs.

// File: rtl/bulk_out_ep_csr.sv
module bulk_out_ep_csr #(
  parameter int DW     = 32,
  parameter int BYTE_W = 7,
  parameter int PKT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic [DW-1:0]     csr_wdata,
  output logic [DW-1:0]     csr_rdata,
  input  logic              pkt_done,
  input  logic              pkt_short,
  input  logic              stall_sent,
  input  logic [BYTE_W-1:0] fifo_bytes,
  input  logic [PKT_W-1:0]  fifo_pkts,
  output logic              force_stall
);
  localparam int B_RDY   = 0;
  localparam int B_DONE  = 1;
  localparam int B_SSENT = 3;
  localparam int B_FORCE = 4;
  localparam int B_AVAIL = 5;
  localparam int B_SHORT = 6;

  logic done_q, ssent_q, force_q, short_q;

  wire clr_done  = csr_wr_en & csr_wdata[B_DONE];
  wire clr_ssent = csr_wr_en & csr_wdata[B_SSENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ssent_q <= 1'b0;
      force_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      if (pkt_done)       done_q <= 1'b1;
      else if (clr_done)  done_q <= 1'b0;
      if (stall_sent)     ssent_q <= 1'b1;
      else if (clr_ssent) ssent_q <= 1'b0;
      if (csr_wr_en)      force_q <= csr_wdata[B_FORCE];
      if (pkt_done)       short_q <= pkt_short;
      else if (fifo_pkts == '0) short_q <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_RDY]   = |fifo_pkts;
    csr_rdata[B_DONE]  = done_q;
    csr_rdata[B_SSENT] = ssent_q;
    csr_rdata[B_FORCE] = force_q;
    csr_rdata[B_AVAIL] = |fifo_bytes;
    csr_rdata[B_SHORT] = short_q;
  end

  assign force_stall = force_q;

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> csr_rdata[B_DONE]); // R5
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && csr_wdata[B_DONE] && !pkt_done) |=> !csr_rdata[B_DONE]); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !(csr_wr_en && csr_wdata[B_DONE])) |=> $stable(csr_rdata[B_DONE])); // R5
  AST_SSENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> csr_rdata[B_SSENT]); // R6
  AST_SSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_sent && !(csr_wr_en && csr_wdata[B_SSENT])) |=> $stable(csr_rdata[B_SSENT])); // R6
  AST_FORCE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> (force_stall == $past(csr_wdata[B_FORCE]))); // R7
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> $stable(force_stall)); // R7
  AST_SHORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_short) |=> csr_rdata[B_SHORT]); // R8
  AST_SHORT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && fifo_pkts == '0) |=> !csr_rdata[B_SHORT]); // R8
endmodule

// File: tb/bulk_out_ep_csr_tb_top.sv
`timescale 1ns/1ps
module bulk_out_ep_csr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic done = 1'b0, shrt = 1'b0, ss = 1'b0;
  logic [6:0] bytes = '0;
  logic [1:0] pkts = '0;
  logic fst;

  int checks = 0, fails = 0;
  int m_done = 0, m_ss = 0, m_force = 0, m_short = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bulk_out_ep_csr dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(wr), .csr_wdata(wd), .csr_rdata(rd),
    .pkt_done(done), .pkt_short(shrt), .stall_sent(ss),
    .fifo_bytes(bytes), .fifo_pkts(pkts), .force_stall(fst));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 reserved bits", int'(rd[31:7]) + int'(rd[2]), 0);
    chk("R3 packet ready", int'(rd[0]), int'(pkts != 0));
    chk("R4 data present", int'(rd[5]), int'(bytes != 0));
    chk("R5 packet complete", int'(rd[1]), m_done);
    chk("R6 stall sent", int'(rd[3]), m_ss);
    chk("R7 force stall bit", int'(rd[4]), m_force);
    chk("R7 force_stall pin", int'(fst), m_force);
    chk("R8 short packet", int'(rd[6]), m_short);
  endtask

  task automatic cyc(bit w, logic [31:0] d, bit pd, bit sh, bit st, int nb, int np);
    wr = w; wd = d; done = pd; shrt = sh; ss = st;
    bytes = 7'(nb); pkts = 2'(np);
    @(posedge clk);
    if (pd) m_done = 1; else if (w && d[1]) m_done = 0;
    if (st) m_ss = 1;   else if (w && d[3]) m_ss = 0;
    if (w) m_force = int'(d[4]);
    if (pd) m_short = int'(sh); else if (np == 0) m_short = 0;
    @(negedge clk);
    wr = 0; done = 0; ss = 0;
    compare_all();
  endtask

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset word", int'(rd), 0);
    chk("R1 reset force_stall", int'(fst), 0);
    // R2 R9: all-ones write: only force stall takes effect
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R9 ro bits after write", int'(rd & 32'h61), 0);
    cyc(1, 32'h0, 0, 0, 0, 0, 0);
    // R5: packet arrives, full size
    cyc(0, 0, 1, 0, 0, 64, 1);
    cyc(1, 32'h0, 0, 0, 0, 64, 1);          // R5 zero write holds
    cyc(1, 32'h2, 0, 0, 0, 64, 1);          // R5 clear
    cyc(1, 32'h2, 1, 1, 0, 100, 2);         // R5 set wins, R8 short
    chk("R5 set wins over clear", int'(rd[1]), 1);
    cyc(0, 0, 0, 0, 0, 36, 1);              // R8 holds while packets left
    cyc(0, 0, 0, 0, 0, 0, 0);               // R8 drain clears
    chk("R8 cleared on drain", int'(rd[6]), 0);
    // R6 stall sent
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(1, 32'h8, 1'b0, 0, 1, 0, 0);        // R6 set wins
    chk("R6 set wins over clear", int'(rd[3]), 1);
    cyc(1, 32'h8, 0, 0, 0, 0, 0);
    chk("R6 cleared", int'(rd[3]), 0);
    // R8 full packet after short clears flag
    cyc(0, 0, 1, 1, 0, 10, 1);
    cyc(0, 0, 1, 0, 0, 74, 2);
    chk("R8 full packet clears", int'(rd[6]), 0);
    // R7 toggle
    cyc(1, 32'h10, 0, 0, 0, 74, 2);
    cyc(0, 0, 0, 0, 0, 74, 2);
    chk("R7 held", int'(fst), 1);
    // random phase
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      int np = (r >> 8) & 3;
      int nb = (np == 0) ? ((r >> 12) & 1) * 5 : ((r >> 13) & 63) + 1;
      cyc(bit'(r & 1), 32'($urandom), bit'((r >> 1) % 4 == 0), bit'((r >> 4) & 1),
          bit'((r >> 5) % 4 == 0), nb, np);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule